// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter with an eight-input analog multiplexer and an optional x16 programmable-gain stage in front of it. A start request captures a 4-bit channel code and a gain choice. The block drives the multiplexer and the phase controls for amplify, track and hold. It then runs a ten-step binary search, MSB first, against a single comparator bit and reports the code with a one-cycle done pulse.

The sequencer clock runs at twice the converter clock, so every phase length is a whole number of sequencer cycles. At unity gain a conversion is 16 converter clocks (32 cycles): track, then hold with ten bit decisions. At gain 16 an amplify phase of 10.5 converter clocks (21 cycles) comes first, for 53 cycles in all. The search is the same for both gains. The comparator, capacitor DAC and amplifier sit outside the block.

Top module: `sarseq_top`

## Requirements
- R1: After synchronous active-low reset, busy, amp_on, track_on, hold_on, mux_valid, done, dac_code and result are all 0.
- R2: Channel codes 0 to 7 select input number `code[2:0]` on sig_sel, with ref_is_gnd=1, ref_sel=0 and mux_valid=1 for the whole conversion.
- R3: Channel codes 8 to 11 select a differential pair: sig_sel = 2*code[1:0] (even input), ref_sel = 2*code[1:0]+1 (odd input), ref_is_gnd=0, mux_valid=1.
- R4: Channel codes 12 to 15 are reserved. mux_valid stays 0 and sig_sel, ref_sel and ref_is_gnd stay 0. The conversion still takes its normal length, and result is 0.
- R5: With gain_hi=0, track_on is high for 12 cycles after the accepting edge, then hold_on for 20 cycles. done rises 32 cycles after the start is accepted.
- R6: With gain_hi=1, amp_on is high for 21 cycles, then track_on for 12, then hold_on for 20. done rises 53 cycles after the start is accepted.
- R7: In hold, each bit decision lasts 2 cycles, from MSB to LSB. dac_code shows the bits kept so far plus the trial bit. comp_in is sampled at the end of the decision, and the trial bit is kept when comp_in=1. The first trial code is 10'h200.
- R8: done is high for exactly one cycle and busy is low in that cycle. result is valid while done is high and holds its value until the next done.
- R9: A start while busy is ignored. chan_code and gain_hi are captured only when a start is accepted, so changes during a conversion do not alter its timing, mux selection or result.
- R10: dac_code is 0 whenever hold_on is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the converter clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, accepted when idle |
| gain_hi | input | 1 | 1 selects gain 16 (adds the amplify phase), 0 selects unity gain |
| chan_code | input | 4 | Channel selection code |
| comp_in | input | 1 | Comparator decision: 1 means input at or above DAC level |
| busy | output | 1 | Conversion in progress |
| amp_on | output | 1 | Amplifier tracking and amplifying |
| track_on | output | 1 | Converter track phase |
| hold_on | output | 1 | Converter hold and bit-decision phase |
| mux_valid | output | 1 | Multiplexer selection is a real input |
| sig_sel | output | 3 | Input routed to the positive side |
| ref_sel | output | 3 | Input routed to the negative side when not ground |
| ref_is_gnd | output | 1 | Negative side tied to analog ground |
| dac_code | output | 10 | Trial code for the capacitor DAC |
| result | output | 10 | Conversion result |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit result, 21 amplify cycles and 12 track cycles. This gives the exact 32- and 53-cycle lengths of the two gain paths. A comparator model answers "target at or above dac_code", so the search must return the target code, including the all-zero and all-ones codes. All sixteen channel codes are used, with a start, a gain change and a channel change injected mid-conversion.

// File: rtl/sarseq_pkg.sv
// Shared types for the SAR conversion sequencer.
// Assumes: one sequencer clock equals half a converter clock.
package sarseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_AMP  = 2'd1,
        PH_TRK  = 2'd2,
        PH_HOLD = 2'd3
    } phase_t;

    typedef struct packed {
        logic       valid;
        logic       gnd_ref;
        logic [2:0] sig;
        logic [2:0] refc;
    } chan_sel_t;

endpackage

// File: rtl/sarseq_decode.sv
// Channel code decoder.
// Maps a 4-bit code to signal/reference mux selections.
// Single-ended codes 0-7, differential pairs 8-11, reserved 12-15.
// Assumes: purely combinational, the caller latches the code.
module sarseq_decode
    import sarseq_pkg::*;
(
    input  logic [3:0] code,
    output chan_sel_t  sel
);

    // Decode the code into mux controls
    always_comb begin
        sel = '0;
        if (!code[3]) begin
            sel.valid   = 1'b1;
            sel.gnd_ref = 1'b1;
            sel.sig     = code[2:0];
        end else if (!code[2]) begin
            sel.valid   = 1'b1;
            sel.sig     = {code[1:0], 1'b0};
            sel.refc    = {code[1:0], 1'b1};
        end
    end

endmodule

// File: rtl/sarseq_timer.sv
// Phase timer for the conversion.
// Runs amplify (gain 16 only), track, then hold with W bit
// decisions of two cycles each, MSB index first.
// Assumes: start is only acted on in the idle phase.
module sarseq_timer
    import sarseq_pkg::*;
#(
    parameter int W      = 10,
    parameter int AMP_HP = 21,
    parameter int TRK_HP = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 gain_hi,
    output phase_t               phase,
    output logic [$clog2(W)-1:0] bit_idx,
    output logic                 launch,
    output logic                 strobe,
    output logic                 last
);

    localparam int MAXHP = (AMP_HP > TRK_HP) ? AMP_HP : TRK_HP;
    localparam int CW    = $clog2(MAXHP + 1);
    localparam int IW    = $clog2(W);

    logic [CW-1:0] cnt;
    logic          half;

    // Strobe and launch decode
    always_comb begin
        launch = start && (phase == PH_IDLE);
        strobe = (phase == PH_HOLD) && half;
        last   = strobe && (bit_idx == '0);
    end

    // Phase state machine and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            half    <= 1'b0;
            bit_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= gain_hi ? PH_AMP : PH_TRK;
                    cnt   <= '0;
                end
                PH_AMP: begin
                    if (cnt == CW'(AMP_HP - 1)) begin
                        phase <= PH_TRK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TRK: begin
                    if (cnt == CW'(TRK_HP - 1)) begin
                        phase   <= PH_HOLD;
                        cnt     <= '0;
                        half    <= 1'b0;
                        bit_idx <= IW'(W - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    half <= ~half;
                    if (half) begin
                        if (bit_idx == '0) phase <= PH_IDLE;
                        else               bit_idx <= bit_idx - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sarseq_sar.sv
// Successive-approximation register.
// Holds the kept bits, forms the trial code and captures the result.
// Assumes: strobe marks the last cycle of each bit decision.
module sarseq_sar #(
    parameter int W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 in_hold,
    input  logic                 strobe,
    input  logic                 last,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 comp,
    input  logic                 keep,
    output logic [W-1:0]         dac_code,
    output logic [W-1:0]         result,
    output logic                 done
);

    logic [W-1:0] acc;
    logic [W-1:0] trial;

    // Trial bit and DAC code
    always_comb begin
        trial    = W'(1) << bit_idx;
        dac_code = in_hold ? (acc | trial) : '0;
    end

    // Accumulate kept bits and publish the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (launch) acc <= '0;
            else if (strobe && comp) acc <= acc | trial;
            if (last) result <= keep ? (acc | (comp ? trial : '0)) : '0;
        end
    end

endmodule

// File: rtl/sarseq_top.sv
// SAR conversion sequencer top.
// Latches channel code at start, drives mux and phase controls,
// runs the binary search and pulses done with the result.
// Assumes: clk is twice the converter clock, comp_in is synchronous.
module sarseq_top
    import sarseq_pkg::*;
#(
    parameter int W      = 10,
    parameter int AMP_HP = 21,
    parameter int TRK_HP = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         gain_hi,
    input  logic [3:0]   chan_code,
    input  logic         comp_in,
    output logic         busy,
    output logic         amp_on,
    output logic         track_on,
    output logic         hold_on,
    output logic         mux_valid,
    output logic [2:0]   sig_sel,
    output logic [2:0]   ref_sel,
    output logic         ref_is_gnd,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         done
);

    localparam int IW = $clog2(W);

    phase_t        phase;
    logic [IW-1:0] bit_idx;
    logic          launch, strobe, last;
    logic [3:0]    code_q;
    chan_sel_t     sel;

    // Capture the channel code on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (launch) code_q <= chan_code;
    end

    sarseq_decode u_dec (
        .code (code_q),
        .sel  (sel)
    );

    sarseq_timer #(.W(W), .AMP_HP(AMP_HP), .TRK_HP(TRK_HP)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .gain_hi (gain_hi),
        .phase   (phase),
        .bit_idx (bit_idx),
        .launch  (launch),
        .strobe  (strobe),
        .last    (last)
    );

    sarseq_sar #(.W(W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .in_hold  (hold_on),
        .strobe   (strobe),
        .last     (last),
        .bit_idx  (bit_idx),
        .comp     (comp_in),
        .keep     (sel.valid),
        .dac_code (dac_code),
        .result   (result),
        .done     (done)
    );

    // Phase and mux outputs
    always_comb begin
        busy       = (phase != PH_IDLE);
        amp_on     = (phase == PH_AMP);
        track_on   = (phase == PH_TRK);
        hold_on    = (phase == PH_HOLD);
        mux_valid  = busy && sel.valid;
        sig_sel    = mux_valid ? sel.sig  : '0;
        ref_sel    = mux_valid ? sel.refc : '0;
        ref_is_gnd = mux_valid && sel.gnd_ref;
    end

endmodule

// File: rtl/sarseq_chk.sv
// Assertion checker for sarseq_top, attached by bind.
// Assumes: observes only top-level ports.
module sarseq_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         amp_on,
    input logic         track_on,
    input logic         hold_on,
    input logic         mux_valid,
    input logic [2:0]   sig_sel,
    input logic [2:0]   ref_sel,
    input logic         ref_is_gnd,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] result,
    input logic         done
);

    assert_phase_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({amp_on, track_on, hold_on}) && (busy == (amp_on | track_on | hold_on)));

    assert_amp_to_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(amp_on) |-> track_on);

    assert_track_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(track_on) |-> hold_on);

    assert_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_on) |-> (dac_code == (W'(1) << (W - 1))));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_mux_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(sig_sel) && $stable(ref_sel) && $stable(ref_is_gnd)));

    assert_dac_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_on |-> (dac_code == '0));

    assert_reserved_mux_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_valid |-> (sig_sel == '0 && ref_sel == '0 && !ref_is_gnd));

endmodule

bind sarseq_top sarseq_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .amp_on     (amp_on),
    .track_on   (track_on),
    .hold_on    (hold_on),
    .mux_valid  (mux_valid),
    .sig_sel    (sig_sel),
    .ref_sel    (ref_sel),
    .ref_is_gnd (ref_is_gnd),
    .dac_code   (dac_code),
    .result     (result),
    .done       (done)
);

// File: tb/sarseq_top_tb.sv
// Scoreboard bench for sarseq_top: a driver pushes expected items,
// a monitor pops them when done arrives and compares.
module sarseq_top_tb;

    localparam int W = 10;

    typedef struct {
        logic [W-1:0] res;
        int           lat;
        int           n_amp;
        int           n_trk;
        int           n_hold;
        logic         mval;
        logic [2:0]   sig;
        logic [2:0]   refc;
        logic         gnd;
        int           t0;
        logic [3:0]   code;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         gain_hi = 1'b0;
    logic [3:0]   chan_code = '0;
    logic         comp_in;
    logic         busy, amp_on, track_on, hold_on, mux_valid, ref_is_gnd, done;
    logic [2:0]   sig_sel, ref_sel;
    logic [W-1:0] dac_code, result;
    logic [W-1:0] target = '0;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   n_done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Comparator model: input at or above DAC level
    assign comp_in = (target >= dac_code);

    sarseq_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gain_hi(gain_hi),
        .chan_code(chan_code), .comp_in(comp_in), .busy(busy),
        .amp_on(amp_on), .track_on(track_on), .hold_on(hold_on),
        .mux_valid(mux_valid), .sig_sel(sig_sel), .ref_sel(ref_sel),
        .ref_is_gnd(ref_is_gnd), .dac_code(dac_code), .result(result),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: start a conversion, optionally disturb it, push expectation
    task automatic convert(input bit g, input logic [3:0] c, input logic [W-1:0] t,
                           input bit disturb);
        exp_t e;
        target    = t;
        gain_hi   = g;
        chan_code = c;
        start     = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        e.t0   = cyc;
        e.code = c;
        e.lat  = g ? 53 : 32;
        e.n_amp  = g ? 21 : 0;
        e.n_trk  = 12;
        e.n_hold = 20;
        if (c < 8) begin
            e.mval = 1; e.sig = c[2:0]; e.refc = 0; e.gnd = 1; e.res = t;
        end else if (c < 12) begin
            e.mval = 1; e.sig = {c[1:0], 1'b0}; e.refc = {c[1:0], 1'b1}; e.gnd = 0; e.res = t;
        end else begin
            e.mval = 0; e.sig = 0; e.refc = 0; e.gnd = 0; e.res = '0;
        end
        sb.push_back(e);
        if (disturb) begin
            // R9: second start with other settings mid-conversion
            repeat (5) @(negedge clk);
            gain_hi = ~g; chan_code = c ^ 4'b1001; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy || done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: count phases and compare on done
    initial begin : monitor
        int na, nt, nh;
        bit first;
        logic mv, gg; logic [2:0] ss, rr;
        exp_t e;
        na = 0; nt = 0; nh = 0; first = 1;
        mv = 0; gg = 0; ss = 0; rr = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (busy) begin
                if (first) begin mv = mux_valid; ss = sig_sel; rr = ref_sel; gg = ref_is_gnd; first = 0; end
                na += int'(amp_on); nt += int'(track_on); nh += int'(hold_on);
            end
            if (done) begin
                n_done++;
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(result == e.res, (e.code >= 12) ? "R4 result" : "R7 result", result, e.res);
                    chk(cyc - e.t0 == e.lat, e.n_amp != 0 ? "R6 latency" : "R5 latency", cyc - e.t0, e.lat);
                    chk(na == e.n_amp, "R6 amp cycles", na, e.n_amp);
                    chk(nt == e.n_trk, "R5 track cycles", nt, e.n_trk);
                    chk(nh == e.n_hold, "R7 hold cycles", nh, e.n_hold);
                    chk(mv == e.mval, "R4 mux_valid", mv, e.mval);
                    chk(ss == e.sig, (e.code[3]) ? "R3 sig_sel" : "R2 sig_sel", ss, e.sig);
                    chk(rr == e.refc, (e.code[3]) ? "R3 ref_sel" : "R2 ref_sel", rr, e.refc);
                    chk(gg == e.gnd, (e.code[3]) ? "R3 ref_is_gnd" : "R2 ref_is_gnd", gg, e.gnd);
                    chk(busy == 0, "R8 busy with done", busy, 0);
                    @(negedge clk);
                    chk(done == 0, "R8 done width", done, 0);
                    chk(result == e.res, "R8 result held", result, e.res);
                    chk(dac_code == 0, "R10 dac idle", dac_code, 0);
                end
                na = 0; nt = 0; nh = 0; first = 1;
            end
        end
    end

    // Watchdog
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, amp_on, track_on, hold_on, mux_valid, done} == 0, "R1 controls", busy, 0);
        chk(dac_code == 0 && result == 0, "R1 data", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 single-ended, both gains
        for (int i = 0; i < 8; i++) convert(i[0], 4'(i), W'(i * 131 + 7), 0);
        // R3 differential pairs
        for (int i = 8; i < 12; i++) convert(i[1], 4'(i), W'(i * 77), 0);
        // R4 reserved codes
        for (int i = 12; i < 16; i++) convert(i[0], 4'(i), W'(700), 0);
        // R7 extremes of the search
        convert(0, 4'd0, '0, 0);
        convert(1, 4'd3, '1, 0);
        convert(0, 4'd5, W'(10'h200), 0);
        convert(1, 4'd9, W'(10'h1FF), 0);
        // R9 start, gain and channel changes while busy
        convert(0, 4'd2, W'(345), 1);
        convert(1, 4'd10, W'(612), 1);
        // R10 DAC quiet while idle
        repeat (4) @(negedge clk);
        chk(dac_code == 0, "R10 dac idle gap", dac_code, 0);
        chk(sb.size() == 0 && n_done == 22, "R9 done count", n_done, 22);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule